// File: doc/BRIEF.md
# AUX Request Engine

This block holds one request for a DisplayPort-style auxiliary channel in a small byte buffer and sends it when software asks. It takes the reply bytes that come back and stores them. It then reports completion, the reply length and any receive faults in a status word. Software works through a 32-bit word-indexed register bus. The buffer is filled through one indexed data port. By default the port's pointer advances on every access, and a control bit loads the pointer from an index field instead.

Software builds the header in the buffer in this order:
- byte 0 is the command, in its upper nibble;
- byte 1 is the high address byte;
- byte 2 is the low address byte;
- byte 3 is the length minus one. It is present only for a request with a nonzero length.

Write payload follows the header. Software then writes the total byte count together with the go bit. The engine streams exactly that many bytes toward a serializer over a valid/ready handshake and then waits for reply bytes from a receiver. The receiver marks the end of a reply with a separate end pulse.

After a reply, software selects read direction at index 0 and reads the reply bytes back through the same data port. The first byte is the reply code, in its upper nibble. The remaining bytes are read data.

If no reply byte arrives within a programmable number of cycles, the engine finishes with a timeout flag. A reply longer than the 17-byte receive area is cut short and flagged as an overflow.

Top module: `auxq_engine`

## Requirements
- R1: After a GO, the engine sends buffer bytes from index 0 upward, exactly the programmed count of them, on `tx_data`. `tx_last` is high with the final byte. With the header convention above, an address-only request is 3 bytes and a write of N bytes is 4+N bytes.
- R2: A write to the data port (word 4) stores bits 15:8 into the request buffer. If bit 0 is 0 and bit 31 is 1, the byte goes to the index in bits 20:16. If bit 31 is 0, the byte goes to the current pointer and the index field is ignored. Either way the pointer then becomes the used index plus one.
- R3: A data-port write with bit 0 set selects read direction. With bit 31 set, it also loads the pointer from bits 20:16. Each later data-port read returns the reply byte at the pointer in bits 15:8 and then advances the pointer. Reply byte 0 holds the reply code.
- R4: A write to the software-control register (word 1) with bit 0 set starts a transaction of bits 20:16 bytes. It is ignored while the channel enable (control word 0, bit 0) is clear.
- R5: A GO written while a transaction is in progress is ignored. The transaction that is running continues unchanged. Status bit 1 reads 1 while a transaction is in progress.
- R6: Status (word 3) bit 0 (DONE) is set only when the reply ends. Bits 28:24 then hold the number of reply bytes stored.
- R7: Writing 1 to bit 1 of the interrupt-control register (word 2) clears DONE.
- R8: If no reply byte arrives within the cycle limit in control bits 31:16 after the last byte is sent, the engine sets status bit 7, bit 2 (failed) and DONE, with a reply count of 0.
- R9: A reply longer than 17 bytes sets status bit 8 and bit 2. The bytes past the 17th are discarded and the count stays at 17.
- R10: Receive fault inputs set sticky status bits until the next GO, and each of them also sets bit 2. `rx_fault[0]` (partial byte) sets bit 10, `rx_fault[1]` (invalid start) sets bit 19 and `rx_fault[2]` (invalid stop) sets bit 14.
- R11: After reset the status word reads 0 and `tx_valid` is low.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and the byte offered does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word index |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe (advances the data-port pointer) |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| tx_valid | output | 1 | Request byte offered to the serializer |
| tx_data | output | 8 | Request byte |
| tx_last | output | 1 | Marks the final request byte |
| tx_ready | input | 1 | Serializer accepts the byte |
| rx_valid | input | 1 | Reply byte present |
| rx_data | input | 8 | Reply byte |
| rx_end | input | 1 | End of reply marker |
| rx_fault | input | 3 | Receive faults: partial byte, invalid start, invalid stop |

## Verification
The hardest state to reach is a second GO landing while a request is still going out. The bench reaches it by holding `tx_ready` low before the first GO and writing a shorter GO while the stream is stalled. It then checks that the full original byte sequence comes out. Timeout, overflow and fault replies are reached by the bench's link model, which sends no reply, sends 20 bytes, or raises a fault pulse partway through a reply. Random transactions vary the direction, the length (0 to 16), the buffer fill order (auto-increment or explicit reversed indices) and the serializer backpressure.

// File: rtl/auxq_pkg.sv
`timescale 1ns/1ps
package auxq_pkg;

    localparam int PTR_W = 5;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_SWCTL  = 3'd1;
    localparam logic [2:0] A_INTCTL = 3'd2;
    localparam logic [2:0] A_STATUS = 3'd3;
    localparam logic [2:0] A_DATA   = 3'd4;

    localparam int B_GO    = 0;
    localparam int B_ACK   = 1;
    localparam int B_RDSEL = 0;
    localparam int B_NOINC = 31;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SEND,
        SQ_WAIT,
        SQ_RECV
    } sq_state_e;

    // fault[0] partial byte, fault[1] invalid start, fault[2] invalid stop
    typedef struct packed {
        logic             done;
        logic             busy;
        logic             tmo;
        logic             ovf;
        logic [2:0]       fault;
        logic [PTR_W-1:0] count;
    } xact_stat_t;

    function automatic logic [31:0] pack_status(xact_stat_t s);
        logic [31:0] w;
        w        = '0;
        w[0]     = s.done;
        w[1]     = s.busy;
        w[2]     = s.tmo | s.ovf | (|s.fault);
        w[7]     = s.tmo;
        w[8]     = s.ovf;
        w[10]    = s.fault[0];
        w[14]    = s.fault[2];
        w[19]    = s.fault[1];
        w[28:24] = s.count;
        return w;
    endfunction

endpackage

// File: rtl/auxq_bytebuf.sv
`timescale 1ns/1ps
module auxq_bytebuf
    import auxq_pkg::*;
#(
    parameter int DEPTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
            mem[wr_idx[AW-1:0]] <= wr_byte;
        end
    end

    // Indices past the end read as zero.
    assign rd_byte = (int'(rd_idx) < DEPTH) ? mem[rd_idx[AW-1:0]] : 8'h00;

endmodule

// File: rtl/auxq_hostport.sv
`timescale 1ns/1ps
module auxq_hostport
    import auxq_pkg::*;
#(
    parameter int TMO_W   = 16,
    parameter int DEF_TMO = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [31:0]      bus_wdata,
    input  logic             bus_rd,
    output logic [31:0]      bus_rdata,
    input  xact_stat_t       stat,
    input  logic [7:0]       rx_byte,
    output logic             chan_en,
    output logic [TMO_W-1:0] tmo_limit,
    output logic             go_pulse,
    output logic [PTR_W-1:0] go_count,
    output logic             ack_pulse,
    output logic             tx_we,
    output logic [PTR_W-1:0] tx_widx,
    output logic [7:0]       tx_wbyte,
    output logic [PTR_W-1:0] rx_ridx
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    logic             en_q;
    logic [TMO_W-1:0] tmo_q;
    logic [PTR_W-1:0] sw_cnt_q;
    logic [PTR_W-1:0] ptr_q;
    logic             rd_dir_q;

    logic             wr_ctrl, wr_sw, wr_data, rd_data;
    logic [PTR_W-1:0] base_idx;
    logic             unused_wbits;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_sw   = bus_wr && (bus_addr == A_SWCTL);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && (bus_addr == A_DATA);

    // Explicit index when auto-increment is overridden, running pointer otherwise.
    assign base_idx = bus_wdata[B_NOINC] ? bus_wdata[20:16] : ptr_q;

    assign go_pulse  = wr_sw && bus_wdata[B_GO];
    assign go_count  = bus_wdata[20:16];
    assign ack_pulse = bus_wr && (bus_addr == A_INTCTL) && bus_wdata[B_ACK];

    assign tx_we    = wr_data && !bus_wdata[B_RDSEL];
    assign tx_widx  = base_idx;
    assign tx_wbyte = bus_wdata[15:8];
    assign rx_ridx  = ptr_q;

    assign chan_en   = en_q;
    assign tmo_limit = tmo_q;

    assign unused_wbits = ^bus_wdata[7:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            tmo_q    <= TMO_W'(DEF_TMO);
            sw_cnt_q <= '0;
            ptr_q    <= '0;
            rd_dir_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= bus_wdata[0];
                tmo_q <= bus_wdata[16 +: TMO_W];
            end
            if (wr_sw) sw_cnt_q <= bus_wdata[20:16];
            if (wr_data) begin
                rd_dir_q <= bus_wdata[B_RDSEL];
                ptr_q    <= bus_wdata[B_RDSEL] ? base_idx : base_idx + PTR_ONE;
            end else if (rd_data && rd_dir_q) begin
                ptr_q <= ptr_q + PTR_ONE;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[0]            = en_q;
                bus_rdata[16 +: TMO_W]  = tmo_q;
            end
            A_SWCTL:  bus_rdata[20:16] = sw_cnt_q;
            A_STATUS: bus_rdata = pack_status(stat);
            A_DATA: begin
                bus_rdata[0]     = rd_dir_q;
                bus_rdata[20:16] = ptr_q;
                bus_rdata[15:8]  = rd_dir_q ? rx_byte : 8'h00;
            end
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/auxq_link_seq.sv
`timescale 1ns/1ps
module auxq_link_seq
    import auxq_pkg::*;
#(
    parameter int RX_DEPTH = 17,
    parameter int TMO_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_en,
    input  logic             go,
    input  logic [PTR_W-1:0] go_count,
    input  logic             ack,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic [PTR_W-1:0] tx_ridx,
    input  logic [7:0]       tx_rbyte,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    input  logic             tx_ready,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_end,
    input  logic [2:0]       rx_fault,
    output logic             rx_we,
    output logic [PTR_W-1:0] rx_widx,
    output logic [7:0]       rx_wbyte,
    output xact_stat_t       stat
);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
    localparam logic [TMO_W-1:0] TMO_ONE = TMO_W'(1);

    sq_state_e        state_q;
    logic [PTR_W-1:0] tx_idx_q;
    logic [PTR_W-1:0] tx_total_q;
    logic [PTR_W-1:0] rx_cnt_q;
    logic [TMO_W-1:0] tmo_cnt_q;
    logic             done_q, tmo_q, ovf_q;
    logic [2:0]       fault_q;

    logic start, listening, room, tx_fire;

    assign start     = go && chan_en && (state_q == SQ_IDLE);
    assign listening = (state_q == SQ_WAIT) || (state_q == SQ_RECV);
    assign room      = int'(rx_cnt_q) < RX_DEPTH;

    assign tx_valid = (state_q == SQ_SEND);
    assign tx_ridx  = tx_idx_q;
    assign tx_data  = tx_rbyte;
    assign tx_last  = (tx_idx_q == tx_total_q - PTR_ONE);
    assign tx_fire  = tx_valid && tx_ready;

    assign rx_we    = listening && rx_valid && room;
    assign rx_widx  = rx_cnt_q;
    assign rx_wbyte = rx_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            tx_idx_q   <= '0;
            tx_total_q <= '0;
            rx_cnt_q   <= '0;
            tmo_cnt_q  <= '0;
            done_q     <= 1'b0;
            tmo_q      <= 1'b0;
            ovf_q      <= 1'b0;
            fault_q    <= '0;
        end else begin
            if (ack) done_q <= 1'b0;
            if (listening) fault_q <= fault_q | rx_fault;
            if (listening && rx_valid) begin
                if (room) rx_cnt_q <= rx_cnt_q + PTR_ONE;
                else      ovf_q    <= 1'b1;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (start) begin
                        done_q     <= 1'b0;
                        tmo_q      <= 1'b0;
                        ovf_q      <= 1'b0;
                        fault_q    <= '0;
                        rx_cnt_q   <= '0;
                        tx_idx_q   <= '0;
                        tx_total_q <= go_count;
                        tmo_cnt_q  <= '0;
                        state_q    <= (go_count == '0) ? SQ_WAIT : SQ_SEND;
                    end
                end
                SQ_SEND: begin
                    if (tx_fire) begin
                        if (tx_last) begin
                            state_q   <= SQ_WAIT;
                            tmo_cnt_q <= '0;
                        end else begin
                            tx_idx_q <= tx_idx_q + PTR_ONE;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (rx_end) begin
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else if (rx_valid) begin
                        state_q <= SQ_RECV;
                    end else if (tmo_cnt_q == tmo_limit) begin
                        tmo_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end else begin
                        tmo_cnt_q <= tmo_cnt_q + TMO_ONE;
                    end
                end
                SQ_RECV: begin
                    if (rx_end) begin
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        stat.done  = done_q;
        stat.busy  = (state_q != SQ_IDLE);
        stat.tmo   = tmo_q;
        stat.ovf   = ovf_q;
        stat.fault = fault_q;
        stat.count = rx_cnt_q;
    end

    // R4: a disabled channel never leaves idle
    assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && !chan_en) |=> (state_q == SQ_IDLE))
        else $error("GO accepted with channel disabled");

    // R5: GO during a transaction leaves its length untouched
    assert_go_busy_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_IDLE && go) |=> (tx_total_q == $past(tx_total_q)))
        else $error("GO restarted a busy transaction");

    // R6: DONE is only seen with the engine idle
    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == SQ_IDLE))
        else $error("DONE while busy");

    // R8: a timeout completes the transaction with no stored reply
    assert_timeout_empty_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_q) |-> (done_q && rx_cnt_q == '0))
        else $error("timeout without DONE or with reply bytes");

    // R9: stored reply count never exceeds the receive area
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        int'(rx_cnt_q) <= RX_DEPTH)
        else $error("reply count beyond receive area");

    // R12: a stalled byte is held
    assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_ridx) && $stable(tx_last)))
        else $error("request byte dropped under backpressure");

endmodule

// File: rtl/auxq_engine.sv
`timescale 1ns/1ps
module auxq_engine
    import auxq_pkg::*;
#(
    parameter int MAX_PAYLOAD = 16,
    parameter int TMO_W       = 16,
    parameter int DEF_TMO     = 400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_end,
    input  logic [2:0]  rx_fault
);
    localparam int TX_DEPTH = MAX_PAYLOAD + 4;
    localparam int RX_DEPTH = MAX_PAYLOAD + 1;

    xact_stat_t       stat;
    logic             chan_en, go_pulse, ack_pulse;
    logic [PTR_W-1:0] go_count;
    logic [TMO_W-1:0] tmo_limit;
    logic             tx_we;
    logic [PTR_W-1:0] tx_widx, tx_ridx, rx_widx, rx_ridx;
    logic [7:0]       tx_wbyte, tx_rbyte, rx_wbyte, rx_rbyte;
    logic             rx_we;

    auxq_hostport #(.TMO_W(TMO_W), .DEF_TMO(DEF_TMO)) u_host (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .stat(stat), .rx_byte(rx_rbyte),
        .chan_en(chan_en), .tmo_limit(tmo_limit),
        .go_pulse(go_pulse), .go_count(go_count), .ack_pulse(ack_pulse),
        .tx_we(tx_we), .tx_widx(tx_widx), .tx_wbyte(tx_wbyte),
        .rx_ridx(rx_ridx)
    );

    auxq_bytebuf #(.DEPTH(TX_DEPTH)) u_txbuf (
        .clk(clk), .rst(rst),
        .wr_en(tx_we), .wr_idx(tx_widx), .wr_byte(tx_wbyte),
        .rd_idx(tx_ridx), .rd_byte(tx_rbyte)
    );

    auxq_bytebuf #(.DEPTH(RX_DEPTH)) u_rxbuf (
        .clk(clk), .rst(rst),
        .wr_en(rx_we), .wr_idx(rx_widx), .wr_byte(rx_wbyte),
        .rd_idx(rx_ridx), .rd_byte(rx_rbyte)
    );

    auxq_link_seq #(.RX_DEPTH(RX_DEPTH), .TMO_W(TMO_W)) u_seq (
        .clk(clk), .rst(rst),
        .chan_en(chan_en), .go(go_pulse), .go_count(go_count),
        .ack(ack_pulse), .tmo_limit(tmo_limit),
        .tx_ridx(tx_ridx), .tx_rbyte(tx_rbyte),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_fault(rx_fault),
        .rx_we(rx_we), .rx_widx(rx_widx), .rx_wbyte(rx_wbyte),
        .stat(stat)
    );

    // R11: nothing is offered to the serializer in the cycle after reset
    assert_reset_quiet_R11: assert property (@(posedge clk)
        $past(rst) |-> !tx_valid)
        else $error("tx_valid right after reset");

endmodule

// File: tb/auxq_engine_bench.sv
`timescale 1ns/1ps
module auxq_engine_bench;

    localparam logic [2:0] W_CTRL = 3'd0, W_SW = 3'd1, W_INT = 3'd2, W_ST = 3'd3, W_DATA = 3'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0, rx_end = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [2:0]  rx_fault = '0;

    int n_chk = 0, n_err = 0;
    bit hold_ready = 1'b0;

    logic [7:0] exp_tx [0:31];
    logic [7:0] rep    [0:31];
    logic [7:0] cap    [0:63];
    int cap_n = 0;
    int last_idx = -1;

    always #2.5 clk = ~clk;

    auxq_engine u_auxq_engine (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end), .rx_fault(rx_fault)
    );

    always @(negedge clk) tx_ready = hold_ready ? 1'b0 : (($urandom % 4) != 0);

    always @(posedge clk) begin
        if (tx_valid && tx_ready) begin
            if (cap_n < 64) cap[cap_n] = tx_data;
            if (tx_last) last_idx = cap_n;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] dport(bit noinc, logic [4:0] idx, logic [7:0] b, bit rsel);
        return {noinc, 10'b0, idx, b, 7'b0, rsel};
    endfunction

    function automatic logic [31:0] go_word(int cnt);
        logic [4:0] c = cnt[4:0];
        return {11'b0, c, 15'b0, 1'b1};
    endfunction

    // Header convention: command nibble, address high, address low, length-1, payload
    function automatic int build_req(bit wr, logic [3:0] cmd, logic [15:0] adr, int len);
        int nb;
        exp_tx[0] = {cmd, 4'h0};
        exp_tx[1] = adr[15:8];
        exp_tx[2] = adr[7:0];
        nb = 3;
        if (len > 0) begin
            exp_tx[3] = 8'(len - 1);
            nb = 4;
            if (wr) begin
                for (int i = 0; i < len; i++) exp_tx[4 + i] = 8'($urandom);
                nb = nb + len;
            end
        end
        return nb;
    endfunction

    task automatic run_xact(input bit wr, input int len, input int rn, input logic [2:0] flt,
                            input bit rev, input bit go_twice);
        int nb, ec, k;
        logic [31:0] st, rd;
        nb = build_req(wr, 4'($urandom), 16'($urandom), len);
        // R2: fill by auto-increment (index field garbage) or by explicit reversed indices
        if (!rev) begin
            bus_write(W_DATA, dport(1'b1, 5'd0, exp_tx[0], 1'b0));
            for (int i = 1; i < nb; i++) bus_write(W_DATA, dport(1'b0, 5'(~i), exp_tx[i], 1'b0));
        end else begin
            for (int i = nb - 1; i >= 0; i--) bus_write(W_DATA, dport(1'b1, 5'(i), exp_tx[i], 1'b0));
        end
        bus_write(W_INT, 32'h2);
        cap_n = 0;
        last_idx = -1;
        if (go_twice) hold_ready = 1'b1;
        bus_write(W_SW, go_word(nb));
        if (go_twice) begin
            repeat (4) @(negedge clk);
            bus_read(W_ST, st);
            check(st[1] == 1'b1, "R5 busy bit while stalled", st, 32'h2);
            bus_write(W_SW, go_word(2));
            hold_ready = 1'b0;
        end
        k = 0;
        while (cap_n < nb && k < 2000) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
        check(cap_n == nb, "R1 streamed byte count", cap_n, nb);
        for (int i = 0; i < nb && i < 64; i++)
            check(cap[i] == exp_tx[i], "R1 streamed byte", cap[i], exp_tx[i]);
        check(last_idx == nb - 1, "R1 last marker position", last_idx, nb - 1);
        bus_read(W_ST, st);
        check(st[1:0] == 2'b10, "R6 busy and not done before reply", st, 32'h2);

        if (rn > 0) begin
            rep[0] = {4'($urandom), 4'h0};
            for (int i = 1; i < rn; i++) rep[i] = 8'($urandom);
            for (int i = 0; i < rn; i++) begin
                @(negedge clk);
                rx_valid = 1'b1; rx_data = rep[i];
                rx_fault = (i == 1) ? flt : 3'b000;
            end
            @(negedge clk);
            rx_valid = 1'b0; rx_fault = 3'b000; rx_end = 1'b1;
            @(negedge clk);
            rx_end = 1'b0;
        end
        ec = (rn > 17) ? 17 : rn;
        st = '0;
        for (int p = 0; p < 400; p++) begin
            bus_read(W_ST, st);
            if (st[0]) break;
        end
        check(st[1:0] == 2'b01, "R6 done and idle", st, 32'h1);
        check(st[28:24] == 5'(ec), "R6 reply count", st[28:24], ec);
        check(st[7] == (rn == 0), "R8 timeout bit", st[7], (rn == 0));
        check(st[8] == (rn > 17), "R9 overflow bit", st[8], (rn > 17));
        check({st[14], st[19], st[10]} == flt, "R10 fault bits", {st[14], st[19], st[10]}, flt);
        check(st[2] == ((rn == 0) || (rn > 17) || (flt != 0)), "R10 failed bit", st[2],
              ((rn == 0) || (rn > 17) || (flt != 0)));

        if (ec > 0) begin
            bus_write(W_DATA, dport(1'b1, 5'd0, 8'h00, 1'b1));
            for (int i = 0; i < ec; i++) begin
                bus_read(W_DATA, rd);
                check(rd[15:8] == rep[i], "R3 reply byte readback", rd[15:8], rep[i]);
            end
            if (ec > 3) begin
                bus_write(W_DATA, dport(1'b1, 5'd2, 8'h00, 1'b1));
                bus_read(W_DATA, rd);
                check(rd[15:8] == rep[2], "R3 pointer load at index 2", rd[15:8], rep[2]);
            end
        end
        bus_write(W_INT, 32'h2);
        bus_read(W_ST, st);
        check(st[0] == 1'b0, "R7 ack clears DONE", st, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] st;
        int unsigned seed;
        seed = $urandom(32'd7151);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        bus_read(W_ST, st);
        check(st == 32'h0, "R11 status after reset", st, 32'h0);
        check(tx_valid == 1'b0, "R11 tx_valid after reset", tx_valid, 1'b0);

        // R4: GO with channel disabled
        cap_n = 0;
        bus_write(W_SW, go_word(3));
        repeat (20) @(negedge clk);
        check(cap_n == 0, "R4 no bytes while disabled", cap_n, 0);
        bus_read(W_ST, st);
        check(st[1] == 1'b0, "R4 not busy while disabled", st, 32'h0);

        bus_write(W_CTRL, {16'd40, 15'b0, 1'b1});

        run_xact(1'b1, 4, 1, 3'b000, 1'b0, 1'b1);   // R5 second GO while stalled
        run_xact(1'b0, 0, 0, 3'b000, 1'b0, 1'b0);   // R8 address-only, no reply
        run_xact(1'b0, 16, 20, 3'b000, 1'b1, 1'b0); // R9 overlong reply
        run_xact(1'b0, 1, 2, 3'b010, 1'b0, 1'b0);   // R10 invalid start
        run_xact(1'b0, 2, 3, 3'b101, 1'b0, 1'b0);   // R10 partial byte and invalid stop
        run_xact(1'b1, 16, 1, 3'b000, 1'b1, 1'b0);  // R1 longest write

        for (int t = 0; t < 30; t++) begin
            bit wr;
            int len, rn;
            wr  = 1'($urandom);
            len = $urandom % 17;
            rn  = wr ? 1 : (((t % 3) == 0) ? 1 + ($urandom % 3) : len + 1);
            run_xact(wr, len, rn, 3'b000, 1'($urandom), 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule